// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction fires. It takes two operands, a five-bit condition selector and a width select. It evaluates five relations between the operands: signed less-than, signed greater-than, equal, unsigned less-than and unsigned greater-than. If any relation that the selector enables is true, the block requests a trap.

An execute stage presents one comparison per cycle by raising the valid strobe. One clock later, the block raises a completion flag for exactly one cycle. In that same cycle it gives the verdict as a trap-request pulse and a program-exception cause code. Steering to a handler and flushing the pipeline are left to the logic that consumes the pulse.

Top module: `trap_cmp_unit`

## Requirements
- R1: Selector bit 4 (value 0x10) traps when the first operand is less than the second, both read as two's-complement signed.
- R2: Selector bit 3 (value 0x08) traps when the first operand is greater than the second, both read as signed.
- R3: Selector bit 2 (value 0x04) traps when the two compared operands are equal.
- R4: Selector bit 1 (value 0x02) traps when the first operand is less than the second, both read as unsigned.
- R5: Selector bit 0 (value 0x01) traps when the first operand is greater than the second, both read as unsigned.
- R6: With `dwordMode` low, only bits 31:0 of each operand take part. Bit 31 is the sign, and bits 63:32 have no effect on the verdict.
- R7: With `dwordMode` high, all 64 bits take part, and bit 63 is the sign.
- R8: A selector of all zeros never raises a trap, whatever the operands.
- R9: A selector of all ones always raises a trap, whatever the operands.
- R10: Each cycle with `inValid` high produces `done` high in the following cycle, for one cycle. `trapReq` can be high only in such a cycle. Back-to-back strobes give back-to-back results.
- R11: `causeCode` is 4'h4 (trap subcode) in a cycle where `trapReq` is high, and 4'h0 in every other cycle.
- R12: While reset is held and right after it is released, `trapReq`, `done` and `causeCode` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and selector are presented this cycle |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| condMask | input | 5 | Relation enables: bit4 signed <, bit3 signed >, bit2 ==, bit1 unsigned <, bit0 unsigned > |
| dwordMode | input | 1 | 1 compares 64 bits, 0 compares the low 32 bits |
| trapReq | output | 1 | One-cycle trap request |
| causeCode | output | 4 | Program-exception cause, 4'h4 on a trap, else 0 |
| done | output | 1 | One-cycle flag marking a finished comparison |

## Verification
The hardest cases to reach from the ports are those where the signed and unsigned readings disagree, and those where bits above the word boundary would change the answer if they leaked into a word-mode compare. Random operands almost never produce equal low words with different upper halves, or a low word whose sign bit differs from bit 63. The stimulus therefore builds such pairs on purpose. It applies the same pair in both width modes and checks that the verdict flips. Back-to-back strobes mixed with idle cycles then check that each result lines up with its own strobe.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

  // selector width and the bit each relation listens to
  localparam int MASK_W   = 5;
  localparam int BIT_SLT  = 4;
  localparam int BIT_SGT  = 3;
  localparam int BIT_EQ   = 2;
  localparam int BIT_ULT  = 1;
  localparam int BIT_UGT  = 0;

  localparam int CAUSE_W  = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h4;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'h0;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

endpackage

// File: rtl/trap_cmp_ctrl.sv
module trap_cmp_ctrl
  import trap_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        doneOut
);

  logic doneQ;

  always_comb begin
    strobe.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
    end else begin
      doneQ <= inValid;
    end
  end

  assign doneOut = doneQ;

  // R10: every strobe yields a completion one cycle later, and only then
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> doneOut);
  assert_no_stray_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !doneOut);

endmodule

// File: rtl/trap_cmp_dp.sv
module trap_cmp_dp
  import trap_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [MASK_W-1:0]   condMask,
  input  logic                dwordMode,
  output logic                trapOut,
  output logic [CAUSE_W-1:0]  causeOut
);

  localparam int EXT_W = DATA_W - WORD_W;

  logic signed [DATA_W-1:0] sA, sB;
  logic        [DATA_W-1:0] uA, uB;
  logic        [MASK_W-1:0] relVec;
  logic                     hitAny;
  logic                     trapQ;
  logic        [CAUSE_W-1:0] causeQ;

  // operand narrowing: only exists when the word is shorter than the datapath
  generate
    if (EXT_W > 0) begin : gNarrow
      always_comb begin
        if (dwordMode) begin
          sA = opA;
          sB = opB;
          uA = opA;
          uB = opB;
        end else begin
          sA = {{EXT_W{opA[WORD_W-1]}}, opA[WORD_W-1:0]};
          sB = {{EXT_W{opB[WORD_W-1]}}, opB[WORD_W-1:0]};
          uA = {{EXT_W{1'b0}}, opA[WORD_W-1:0]};
          uB = {{EXT_W{1'b0}}, opB[WORD_W-1:0]};
        end
      end
    end else begin : gFull
      logic unusedMode;
      assign unusedMode = dwordMode;
      always_comb begin
        sA = opA;
        sB = opB;
        uA = opA;
        uB = opB;
      end
    end
  endgenerate

  always_comb begin
    relVec          = '0;
    relVec[BIT_SLT] = (sA < sB);
    relVec[BIT_SGT] = (sA > sB);
    relVec[BIT_EQ]  = (uA == uB);
    relVec[BIT_ULT] = (uA < uB);
    relVec[BIT_UGT] = (uA > uB);
  end

  assign hitAny = |(relVec & condMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapQ  <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else begin
      trapQ  <= strobe.load & hitAny;
      causeQ <= (strobe.load & hitAny) ? CAUSE_TRAP : CAUSE_NONE;
    end
  end

  assign trapOut  = trapQ;
  assign causeOut = causeQ;

  // R9: exactly one signed and one unsigned ordering holds for any pair
  assert_signed_order_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({relVec[BIT_SLT], relVec[BIT_SGT], relVec[BIT_EQ]}) == 1);
  assert_unsigned_order_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({relVec[BIT_ULT], relVec[BIT_UGT], relVec[BIT_EQ]}) == 1);

endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
  import trap_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [DATA_W-1:0]      opA,
  input  logic [DATA_W-1:0]      opB,
  input  logic [MASK_W-1:0]      condMask,
  input  logic                   dwordMode,
  output logic                   trapReq,
  output logic [CAUSE_W-1:0]     causeCode,
  output logic                   done
);

  ctrlStrobe_t strobe;

  trap_cmp_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .doneOut (done)
  );

  trap_cmp_dp #(
    .DATA_W (DATA_W),
    .WORD_W (WORD_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .condMask  (condMask),
    .dwordMode (dwordMode),
    .trapOut   (trapReq),
    .causeOut  (causeCode)
  );

  // R10: a trap only accompanies a completion
  assert_trap_needs_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> done);
  // R11: cause code tracks the trap pulse
  assert_cause_on_trap_R11: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (causeCode == CAUSE_TRAP));
  assert_cause_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |-> (causeCode == CAUSE_NONE));
  // R8: empty selector never traps
  assert_zero_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condMask == '0) |=> !trapReq);
  // R9: full selector always traps
  assert_full_mask_fires_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (&condMask)) |=> trapReq);
  // R3: equal full-width operands with the equality bit set must trap
  assert_equal_fires_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condMask[BIT_EQ] && opA == opB) |=> trapReq);

endmodule

// File: tb/tb_trap_cmp_unit.sv
module tb_trap_cmp_unit;

  localparam time PERIOD = 20ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [4:0]  condMask = '0;
  logic        dwordMode = 1'b0;
  logic        trapReq;
  logic [3:0]  causeCode;
  logic        done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  typedef struct {
    logic       trap;
    logic [3:0] cause;
    string      tag;
  } expItem_t;

  expItem_t sbQ[$];

  always #(PERIOD/2) clk = ~clk;

  trap_cmp_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .condMask(condMask), .dwordMode(dwordMode),
    .trapReq(trapReq), .causeCode(causeCode), .done(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference verdict built from the requirement text
  function automatic logic refTrap(input logic [63:0] a, input logic [63:0] b,
                                   input logic [4:0] m, input logic dw);
    longint sa, sb;
    logic [63:0] ua, ub;
    logic r;
    if (dw) begin
      sa = longint'(a); sb = longint'(b); ua = a; ub = b;
    end else begin
      sa = longint'(int'(a[31:0])); sb = longint'(int'(b[31:0]));
      ua = {32'd0, a[31:0]}; ub = {32'd0, b[31:0]};
    end
    r = (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
        (m[1] && ua < ub) || (m[0] && ua > ub);
    return r;
  endfunction

  // driver: one strobe cycle, expectation pushed to the scoreboard
  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [4:0] m,
                       input logic dw, input string tag, input logic expT);
    expItem_t it;
    @(negedge clk);
    opA = a; opB = b; condMask = m; dwordMode = dw; inValid = 1'b1;
    it.trap  = expT;
    it.cause = expT ? 4'h4 : 4'h0;
    it.tag   = tag;
    if (expT !== refTrap(a, b, m, dw)) begin
      nChecks++; nFails++;
      $display("FAIL %s bench vector inconsistent actual=%0b expected=%0b", tag, refTrap(a, b, m, dw), expT);
    end
    sbQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = 64'hDEAD_BEEF_0BAD_F00D; opB = opA; condMask = 5'h1F;
    end
  endtask

  // monitor: sample a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (rstN && !finished) begin
        if (done) begin
          if (sbQ.size() == 0) begin
            check("R10 stray done", 1, 0);
          end else begin
            expItem_t it;
            it = sbQ.pop_front();
            check({it.tag, " trap"}, trapReq, it.trap);
            check("R11 cause", causeCode, it.cause);
          end
        end else begin
          if (sbQ.size() != 0) check("R10 missing done", 0, 1);
          check("R10 no trap without done", trapReq, 0);
          check("R11 idle cause", causeCode, 0);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 50000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 trap in reset", trapReq, 0);
    check("R12 done in reset", done, 0);
    check("R12 cause in reset", causeCode, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 trap after reset", trapReq, 0);
    check("R12 done after reset", done, 0);

    // R1 signed less-than
    drive(-64'sd5, 64'd3, 5'h10, 1, "R1 lt", 1);
    drive(64'd3, -64'sd5, 5'h10, 1, "R1 not lt", 0);
    // R2 signed greater-than
    drive(64'd3, -64'sd5, 5'h08, 1, "R2 gt", 1);
    drive(64'd7, 64'd7, 5'h08, 1, "R2 equal no gt", 0);
    // R3 equality
    drive(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1, "R3 eq", 1);
    drive(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 5'h04, 1, "R3 ne", 0);
    // R4 unsigned less-than: 3 < large
    drive(64'd3, -64'sd5, 5'h02, 1, "R4 ult", 1);
    drive(-64'sd5, 64'd3, 5'h02, 1, "R4 not ult", 0);
    // R5 unsigned greater-than
    drive(-64'sd5, 64'd3, 5'h01, 1, "R5 ugt", 1);
    drive(64'd3, -64'sd5, 5'h01, 1, "R5 not ugt", 0);
    idle(2);
    // R6 word mode ignores upper halves; same pairs in dword mode differ (R7)
    drive(64'hFFFF_0000_0000_0007, 64'h0000_0000_0000_0007, 5'h04, 0, "R6 eq low word", 1);
    drive(64'hFFFF_0000_0000_0007, 64'h0000_0000_0000_0007, 5'h04, 1, "R7 upper differs", 0);
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 5'h10, 0, "R6 bit31 sign", 1);
    drive(64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 5'h10, 1, "R7 bit63 sign", 0);
    drive(64'h7FFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 5'h08, 0, "R6 upper ignored gt", 0);
    drive(64'h7FFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 5'h08, 1, "R7 full gt", 1);
    drive(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 5'h01, 1, "R7 ugt msb", 1);
    drive(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 5'h01, 0, "R6 ugt low zero", 0);
    idle(1);
    // R8 empty selector
    drive(-64'sd1, 64'd0, 5'h00, 1, "R8 zero mask a", 0);
    drive(64'd9, 64'd9, 5'h00, 0, "R8 zero mask b", 0);
    // R9 full selector
    drive(64'd9, 64'd9, 5'h1F, 0, "R9 full eq", 1);
    drive(-64'sd1, 64'd0, 5'h1F, 1, "R9 full mixed", 1);
    idle(3);
    // R10 alternating strobes and gaps, randomized vectors
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a, b;
      logic [4:0] m;
      logic dw;
      a = {$urandom, $urandom};
      b = (i % 4 == 0) ? a : {$urandom, $urandom};
      if (i % 5 == 0) b[31:0] = a[31:0];
      m = 5'($urandom);
      dw = 1'($urandom);
      drive(a, b, m, dw, "R10 stream", refTrap(a, b, m, dw));
      if (i % 7 == 3) idle(1);
    end
    idle(4);
    check("R10 queue drained", sbQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule